// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small horizontally microcoded 8-bit machine. It keeps a read-only control store of 64 words, each 15 bits wide, and a 6-bit micro address register that selects which word drives the datapath in the current cycle. Every bit of the selected word is one control line: a bus driver enable, a memory strobe, a register load or an ALU function bit. The datapath, the main memory and the buses sit outside this block. Only the low five bits of the data bus come in, and they carry the opcode.

The sequencer has no conditional branches. Two control bits choose the next micro address. Control bit 1 is the most significant bit of the word, and when it is set the micro address returns to zero, where the fetch word is stored. Control bit 2, the next bit down, loads the micro address with the start address of the routine for the opcode on the bus. When neither bit is set, the micro address steps forward by one. The fetch word sets bit 2, so each instruction is read, decoded and then run from its own routine. Every routine ends with a word that has bit 1 set. Control store words that hold no routine read as a word with only bit 1 set, so any stray control flow goes back to fetch.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising edge, `uAddr` is 0 after that edge, whatever the current word holds. In state 0, `uop` reads 011010100000000 (bit 14 of the port is control bit 1).
- R2: When `uop[14]` is 1 and `rst` is low, `uAddr` becomes 0 after the next rising edge.
- R3: When `uop[14]` is 0 and `uop[13]` is 1, `uAddr` becomes the decoded start address of `busLow` after the next rising edge.
- R4: When `uop[14]` and `uop[13]` are both 0, `uAddr` increases by one at the next rising edge, and `busLow` has no effect.
- R5: A high `rst` wins over a load request: during the fetch word, a reset returns `uAddr` to 0 and not to the decoded address.
- R6: Opcodes 0 to 3 decode to start addresses 1, 2, 3 and 5. Opcodes 4 to 12 decode to start addresses 11 to 19, where the start address equals the opcode plus 7.
- R7: Opcodes 13 to 31 decode to start address 1, the no-operation routine.
- R8: Addresses 5 to 10 hold the store routine: 001010101000000, 000000010100000, 000100010100000, 001100010100000, 000100010100000, 100000010100000.
- R9: Address 1 holds 100000000000000. Address 2 holds 101010100010000. Addresses 3 and 4 hold 001010101000000 and 101000000110000. Addresses 11 to 18 hold 100000000001000 plus (address minus 11). Addresses 19 and 20 hold 001010101000000 and 100001000100000.
- R10: `uop` shows the word at `uAddr` in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All state changes on the rising edge. |
| rst | input | 1 | Synchronous reset, active high. Clears the micro address. |
| busLow | input | 5 | Opcode taken from the low bits of the data bus. |
| uAddr | output | 6 | Current micro address. |
| uop | output | 15 | Current control word. Bit 14 is control bit 1. |

## Verification
The bench runs every defined opcode and several undefined ones through the full fetch and routine sequence. In each cycle it compares the micro address and the control word against the table in the requirements. Outside the fetch cycle it drives an unrelated value on the opcode input, so a design that loads on the wrong bit, or that ignores the load bit, jumps to the wrong routine. The six-word store routine checks stepping by one; a design that stalled or skipped a word would show a word out of order. Reset is applied during the fetch word and in the middle of a routine. A design that gave load priority over reset would land on the decoded address and not on 0.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int UOP_W_DEF = 15;
  localparam int UPC_W_DEF = 6;
  localparam int OPC_W_DEF = 5;

  typedef struct packed {
    logic clrSeq;
    logic ldSeq;
  } seqStrobe_t;
endpackage

// File: rtl/useq_decode.sv
`timescale 1ns/1ps
module useq_decode #(
  parameter int OPC_W = useq_pkg::OPC_W_DEF,
  parameter int UPC_W = useq_pkg::UPC_W_DEF
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [UPC_W-1:0] startAddr
);
  localparam int LAST_OPC  = 12;
  localparam int ALU_SHIFT = 7;
  localparam int NOP_ADDR  = 1;

  always_comb begin
    case (opcode)
      OPC_W'(0): startAddr = UPC_W'(1);
      OPC_W'(1): startAddr = UPC_W'(2);
      OPC_W'(2): startAddr = UPC_W'(3);
      OPC_W'(3): startAddr = UPC_W'(5);
      default: begin
        if (int'(opcode) <= LAST_OPC)
          startAddr = UPC_W'(int'(opcode) + ALU_SHIFT);
        else
          startAddr = UPC_W'(NOP_ADDR);
      end
    endcase
  end
endmodule

// File: rtl/useq_store.sv
`timescale 1ns/1ps
module useq_store #(
  parameter int UPC_W = useq_pkg::UPC_W_DEF,
  parameter int UOP_W = useq_pkg::UOP_W_DEF
) (
  input  logic [UPC_W-1:0] uAddr,
  output logic [UOP_W-1:0] uop
);
  localparam int DEPTH = 1 << UPC_W;

  function automatic logic [UOP_W-1:0] romWord(input int a);
    logic [14:0] w;
    case (a)
      0:  w = 15'b011010100000000;
      1:  w = 15'b100000000000000;
      2:  w = 15'b101010100010000;
      3:  w = 15'b001010101000000;
      4:  w = 15'b101000000110000;
      5:  w = 15'b001010101000000;
      6:  w = 15'b000000010100000;
      7:  w = 15'b000100010100000;
      8:  w = 15'b001100010100000;
      9:  w = 15'b000100010100000;
      10: w = 15'b100000010100000;
      19: w = 15'b001010101000000;
      20: w = 15'b100001000100000;
      default: begin
        if (a >= 11 && a <= 18)
          w = 15'b100000000001000 | 15'(a - 11);
        else
          w = 15'b100000000000000;
      end
    endcase
    return UOP_W'(w);
  endfunction

  logic [UOP_W-1:0] romTable [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign romTable[i] = romWord(i);
  end

  assign uop = romTable[uAddr];
endmodule

// File: rtl/useq_path.sv
`timescale 1ns/1ps
module useq_path #(
  parameter int OPC_W = useq_pkg::OPC_W_DEF,
  parameter int UPC_W = useq_pkg::UPC_W_DEF,
  parameter int UOP_W = useq_pkg::UOP_W_DEF
) (
  input  logic [UPC_W-1:0]      uAddr,
  input  logic [OPC_W-1:0]      opcode,
  output logic [UOP_W-1:0]      uop,
  output logic [UPC_W-1:0]      startAddr,
  output useq_pkg::seqStrobe_t  strb
);
  localparam int CLR_BIT = UOP_W - 1;
  localparam int LD_BIT  = UOP_W - 2;

  useq_store #(.UPC_W(UPC_W), .UOP_W(UOP_W)) u_store (
    .uAddr (uAddr),
    .uop   (uop)
  );

  useq_decode #(.OPC_W(OPC_W), .UPC_W(UPC_W)) u_dec (
    .opcode    (opcode),
    .startAddr (startAddr)
  );

  assign strb.clrSeq = uop[CLR_BIT];
  assign strb.ldSeq  = uop[LD_BIT];
endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl #(
  parameter int UPC_W = useq_pkg::UPC_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  useq_pkg::seqStrobe_t strb,
  input  logic [UPC_W-1:0]     startAddr,
  output logic [UPC_W-1:0]     uPC
);
  always_ff @(posedge clk) begin
    if (rst || strb.clrSeq)
      uPC <= '0;
    else if (strb.ldSeq)
      uPC <= startAddr;
    else
      uPC <= uPC + UPC_W'(1);
  end
endmodule

// File: rtl/useq_top.sv
`timescale 1ns/1ps
module useq_top #(
  parameter int OPC_W = useq_pkg::OPC_W_DEF,
  parameter int UPC_W = useq_pkg::UPC_W_DEF,
  parameter int UOP_W = useq_pkg::UOP_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] busLow,
  output logic [UPC_W-1:0] uAddr,
  output logic [UOP_W-1:0] uop
);
  useq_pkg::seqStrobe_t strb;
  logic [UPC_W-1:0]     startAddr;

  useq_path #(.OPC_W(OPC_W), .UPC_W(UPC_W), .UOP_W(UOP_W)) u_path (
    .uAddr     (uAddr),
    .opcode    (busLow),
    .uop       (uop),
    .startAddr (startAddr),
    .strb      (strb)
  );

  useq_ctrl #(.UPC_W(UPC_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .startAddr (startAddr),
    .uPC       (uAddr)
  );
endmodule

// File: rtl/useq_chk.sv
`timescale 1ns/1ps
module useq_chk #(
  parameter int UPC_W = useq_pkg::UPC_W_DEF,
  parameter int UOP_W = useq_pkg::UOP_W_DEF
) (
  input logic             clk,
  input logic             rst,
  input logic [UPC_W-1:0] uAddr,
  input logic [UOP_W-1:0] uop
);
  localparam int MAX_START = 19;

  assert_rst_R1: assert property (@(posedge clk) rst |=> uAddr == '0);

  assert_fetch_word_R1: assert property (@(posedge clk) disable iff (rst)
    (uAddr == '0) |-> (uop == UOP_W'(15'b011010100000000)));

  assert_clr_R2: assert property (@(posedge clk) disable iff (rst)
    uop[UOP_W-1] |=> uAddr == '0);

  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    (!uop[UOP_W-1] && uop[UOP_W-2]) |=>
      (uAddr != '0 && int'(uAddr) <= MAX_START));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!uop[UOP_W-1] && !uop[UOP_W-2]) |=>
      uAddr == UPC_W'($past(uAddr) + UPC_W'(1)));
endmodule

bind useq_top useq_chk #(.UPC_W(UPC_W), .UOP_W(UOP_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .uAddr (uAddr),
  .uop   (uop)
);

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  busLow = 5'd0;
  logic [5:0]  uAddr;
  logic [14:0] uop;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [14:0] FETCH = 15'b011010100000000;

  typedef struct packed {
    logic [5:0]  a;
    logic [14:0] w;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];

  useq_top dut (
    .clk    (clk),
    .rst    (rst),
    .busLow (busLow),
    .uAddr  (uAddr),
    .uop    (uop)
  );

  always #10 clk = ~clk;

  // Expected start address, from R6 and R7
  function automatic int expStart(input int opc);
    case (opc)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 5;
      default: return (opc <= 12) ? opc + 7 : 1;
    endcase
  endfunction

  // Expected control store word, from R1, R8 and R9
  function automatic logic [14:0] expWord(input int a);
    case (a)
      0:  return FETCH;
      1:  return 15'b100000000000000;
      2:  return 15'b101010100010000;
      3:  return 15'b001010101000000;
      4:  return 15'b101000000110000;
      5:  return 15'b001010101000000;
      6:  return 15'b000000010100000;
      7:  return 15'b000100010100000;
      8:  return 15'b001100010100000;
      9:  return 15'b000100010100000;
      10: return 15'b100000010100000;
      19: return 15'b001010101000000;
      20: return 15'b100001000100000;
      default: return 15'b100000000001000 + 15'(a - 11);
    endcase
  endfunction

  task automatic check(input string req, input logic [5:0] gotA, input logic [14:0] gotW,
                       input logic [5:0] expA, input logic [14:0] expW);
    checks++;
    if (gotA !== expA || gotW !== expW) begin
      errors++;
      $display("FAIL %s: uAddr=%0d uop=%b expected uAddr=%0d uop=%b",
               req, gotA, gotW, expA, expW);
    end
  endtask

  task automatic push(input int a, input string tag);
    expItem_t it;
    it.a = 6'(a);
    it.w = expWord(a);
    expQ.push_back(it);
    tagQ.push_back(tag);
  endtask

  // Driver: called at a falling edge with the fetch word showing
  task automatic runInstr(input int opc);
    int a;
    string tag;
    busLow = 5'(opc);
    a = expStart(opc);
    push(a, (opc > 12) ? "R7" : "R6/R3");
    forever begin
      @(negedge clk);
      busLow = 5'(opc) ^ 5'h15;
      if (expWord(a)[14]) begin
        push(0, "R2");
        break;
      end
      a++;
      tag = (a >= 5 && a <= 10) ? "R8/R4" : "R9/R4";
      push(a, tag);
    end
    @(negedge clk);
  endtask

  // Monitor: samples in the middle of the high phase (R10: same-cycle word)
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      expItem_t it;
      string t;
      it = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, uAddr, uop, it.a, it.w);
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", uAddr, uop, 6'd0, FETCH);
    rst = 1'b0;

    for (int opc = 0; opc <= 12; opc++) runInstr(opc);
    runInstr(13);
    runInstr(20);
    runInstr(31);
    runInstr(3);

    // R5: reset while the fetch word requests a load
    busLow = 5'd3;
    rst = 1'b1;
    @(negedge clk);
    check("R5", uAddr, uop, 6'd0, FETCH);
    rst = 1'b0;

    // R1: reset in the middle of the store routine
    busLow = 5'd3;
    @(negedge clk);
    check("R6", uAddr, uop, 6'd5, expWord(5));
    busLow = 5'd7;
    @(negedge clk);
    check("R4", uAddr, uop, 6'd6, expWord(6));
    rst = 1'b1;
    @(negedge clk);
    check("R1", uAddr, uop, 6'd0, FETCH);
    rst = 1'b0;

    runInstr(12);
    runInstr(0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule